// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the eight-bit status register of a small accumulator-style microcontroller core, together with the flag generator that feeds it. The register holds three arithmetic flags: zero, digit carry and carry. It also holds two reset-cause bits (time-out and power-down), one bank-select bit and two reserved bits. The flag generator works on eight-bit operands. It produces the result and the candidate zero, digit-carry and carry values for add, subtract, rotate through carry and the bitwise operations. The carry held in the register is the rotate carry-in.

Instructions that name the register as their destination reach it through an ordinary write port. The register answers at two mirrored addresses, one in each data bank. Each flag has its own update enable from the ALU. When an instruction both writes the register and updates any flag, the flag logic owns all three flag bits and the data write to them is discarded. The write still reaches the bank and reserved bits. The reset-cause bits respond only to the power-up, clear-watchdog, sleep and watchdog-time-out strobes and can never be written as data.

Top module: `sreg_status`

## Requirements
- R1: After synchronous reset `status_q` reads 0x18: time-out (bit 4) and power-down (bit 3) are 1, and every other bit is 0.
- R2: A write takes effect only when `wr_en` is 1 and `wr_addr[6:0]` equals 0x03, so addresses 0x03 and 0x83 both hit. Any other address, such as 0x43 or 0x04, leaves `status_q` unchanged.
- R3: A hitting write loads `wr_data[7:5]` into bits 7:5 on the next clock. Bits 4:3 are never changed by a write.
- R4: When no flag enable is set, a hitting write loads `wr_data[2:0]` into zero (bit 2), digit carry (bit 1) and carry (bit 0). When any of `upd_z`, `upd_dc` or `upd_c` is set, each enabled flag takes the generator's value and each disabled flag holds its value, whether or not a write is present.
- R5: Reset-cause strobes take effect on the next clock. Time-out becomes 1 on power-up; otherwise 0 on watchdog time-out; otherwise 1 on sleep or clear-watchdog. Power-down becomes 1 on power-up; otherwise 0 on sleep; otherwise 1 on clear-watchdog.
- R6: Op code 0 (add) gives the result a+b mod 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is 1 when the result is 0.
- R7: Op code 1 (subtract) gives a−b mod 256, computed as a plus the two's complement of b. C=1 when a≥b, DC=1 when a[3:0]≥b[3:0], and Z marks a zero result.
- R8: Op code 2 (rotate left) gives {a[6:0], carry bit} and C=a[7]. Op code 3 (rotate right) gives {carry bit, a[7:1]} and C=a[0]. In both, DC=0 and Z marks a zero result.
- R9: Op codes 4, 5, 6 and 7 give a AND b, a OR b, a XOR b and a, with DC=0, C=0, and Z marking a zero result.
- R10: With no hitting write, no flag enable and no strobe, `status_q` holds its value.
- R11: `bank_sel` equals bit 5 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Data-write request |
| wr_addr | input | 8 | Data-write address |
| wr_data | input | 8 | Data-write value |
| alu_op | input | 3 | Flag generator operation code |
| alu_a | input | 8 | First operand |
| alu_b | input | 8 | Second operand |
| upd_z | input | 1 | Zero flag update enable |
| upd_dc | input | 1 | Digit-carry flag update enable |
| upd_c | input | 1 | Carry flag update enable |
| ev_powerup | input | 1 | Power-up strobe |
| ev_clrwdt | input | 1 | Clear-watchdog strobe |
| ev_sleep | input | 1 | Sleep strobe |
| ev_wdt_to | input | 1 | Watchdog time-out strobe |
| status_q | output | 8 | Register contents |
| bank_sel | output | 1 | Data bank select |
| alu_res | output | 8 | Flag generator result |
| alu_z | output | 1 | Generated zero flag |
| alu_dc | output | 1 | Generated digit carry |
| alu_c | output | 1 | Generated carry |

## Verification
The bench drives a data write against all eight flag-enable combinations, and also runs each combination without a write. This exposes a design that lets the write leak into a disabled flag, or that lets the write win over the ALU. It clears the register while updating only zero and expects 000uu1uu. A design that handled the three flags one at a time would load zeros into DC and C instead. Strobe pairs such as sleep with watchdog time-out, and power-up with both, catch a wrong priority. An address with only bit 6 different catches a decoder that ignores that bit. Add and subtract are swept over all 65,536 operand pairs, so a wrong borrow polarity or a digit carry taken from the wrong nibble cannot go unnoticed.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
package sreg_pkg;
    localparam int DW = 8;
    localparam int AW = 8;
    localparam int NIB = DW / 2;
    localparam int NFLAG = 3;
    localparam int B_BANK = 5;
    localparam int B_TO = 4;
    localparam int B_PD = 3;
    localparam int B_Z = 2;
    localparam int B_DC = 1;
    localparam int B_C = 0;
    localparam logic [AW-2:0] SREG_OFS = 7'h03;
    localparam logic [DW-1:0] SREG_RST = 8'h18;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_RLC  = 3'd2,
        OP_RRC  = 3'd3,
        OP_AND  = 3'd4,
        OP_IOR  = 3'd5,
        OP_XOR  = 3'd6,
        OP_PASS = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic dc;
        logic c;
    } flags_t;

    typedef struct packed {
        logic pwr;
        logic clrwdt;
        logic sleep;
        logic wdt_to;
    } events_t;

    function automatic logic [NIB:0] nib_sum(input logic [NIB-1:0] x,
                                             input logic [NIB-1:0] y,
                                             input logic ci);
        return {1'b0, x} + {1'b0, y} + {{NIB{1'b0}}, ci};
    endfunction

    function automatic logic [DW:0] byte_sum(input logic [DW-1:0] x,
                                             input logic [DW-1:0] y,
                                             input logic ci);
        return {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
    endfunction
endpackage

// File: rtl/sreg_flag_gen.sv
`timescale 1ns/1ps
module sreg_flag_gen
    import sreg_pkg::*;
(
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic             cin,
    output logic [DW-1:0]    res,
    output flags_t           flg
);
    logic [DW-1:0]  b_eff;
    logic           c_seed;
    logic [DW:0]    wide;
    logic [NIB:0]   low;
    logic           arith;

    always_comb begin
        arith  = (op == OP_ADD) || (op == OP_SUB);
        b_eff  = (op == OP_SUB) ? ~b : b;
        c_seed = (op == OP_SUB);
        wide   = byte_sum(a, b_eff, c_seed);
        low    = nib_sum(a[NIB-1:0], b_eff[NIB-1:0], c_seed);
    end

    always_comb begin
        res    = '0;
        flg.c  = 1'b0;
        flg.dc = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: res = wide[DW-1:0];
            OP_RLC: begin
                res   = {a[DW-2:0], cin};
                flg.c = a[DW-1];
            end
            OP_RRC: begin
                res   = {cin, a[DW-1:1]};
                flg.c = a[0];
            end
            OP_AND:  res = a & b;
            OP_IOR:  res = a | b;
            OP_XOR:  res = a ^ b;
            OP_PASS: res = a;
            default: res = '0;
        endcase
        if (arith) begin
            flg.c  = wide[DW];
            flg.dc = low[NIB];
        end
        flg.z = (res == '0);
    end
endmodule

// File: rtl/sreg_cause.sv
`timescale 1ns/1ps
module sreg_cause
    import sreg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  events_t ev,
    output logic    to_q,
    output logic    pd_q
);
    logic to_d, pd_d;

    always_comb begin
        to_d = to_q;
        if (ev.pwr)                    to_d = 1'b1;
        else if (ev.wdt_to)            to_d = 1'b0;
        else if (ev.sleep | ev.clrwdt) to_d = 1'b1;

        pd_d = pd_q;
        if (ev.pwr)         pd_d = 1'b1;
        else if (ev.sleep)  pd_d = 1'b0;
        else if (ev.clrwdt) pd_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            to_q <= SREG_RST[B_TO];
            pd_q <= SREG_RST[B_PD];
        end else begin
            to_q <= to_d;
            pd_q <= pd_d;
        end
    end
endmodule

// File: rtl/sreg_flag_reg.sv
`timescale 1ns/1ps
module sreg_flag_reg
    import sreg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_hit,
    input  flags_t  wr_flags,
    input  flags_t  upd,
    input  flags_t  alu,
    output flags_t  q
);
    logic [NFLAG-1:0] upd_v, alu_v, wr_v, q_v, d_v;
    logic             any_upd;

    assign upd_v   = upd;
    assign alu_v   = alu;
    assign wr_v    = wr_flags;
    assign any_upd = |upd_v;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_comb begin
            if (upd_v[i])                d_v[i] = alu_v[i];
            else if (wr_hit && !any_upd) d_v[i] = wr_v[i];
            else                         d_v[i] = q_v[i];
        end

        always_ff @(posedge clk) begin
            if (rst) q_v[i] <= SREG_RST[i];
            else     q_v[i] <= d_v[i];
        end
    end

    assign q = q_v;
endmodule

// File: rtl/sreg_bank_bits.sv
`timescale 1ns/1ps
module sreg_bank_bits
    import sreg_pkg::*;
#(
    parameter int NBITS = DW - B_BANK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hit,
    input  logic [NBITS-1:0] wr_val,
    output logic [NBITS-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= SREG_RST[DW-1:B_BANK];
        else if (wr_hit) q <= wr_val;
    end
endmodule

// File: rtl/sreg_status.sv
`timescale 1ns/1ps
module sreg_status
    import sreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    alu_op,
    input  logic [DW-1:0] alu_a,
    input  logic [DW-1:0] alu_b,
    input  logic          upd_z,
    input  logic          upd_dc,
    input  logic          upd_c,
    input  logic          ev_powerup,
    input  logic          ev_clrwdt,
    input  logic          ev_sleep,
    input  logic          ev_wdt_to,
    output logic [DW-1:0] status_q,
    output logic          bank_sel,
    output logic [DW-1:0] alu_res,
    output logic          alu_z,
    output logic          alu_dc,
    output logic          alu_c
);
    logic                 wr_hit;
    flags_t               gen_flags;
    flags_t               upd_flags;
    flags_t               wr_flags;
    flags_t               cur_flags;
    events_t              ev;
    logic                 to_q, pd_q;
    logic [DW-1-B_BANK:0] hi_q;

    assign wr_hit    = wr_en && (wr_addr[AW-2:0] == SREG_OFS);
    assign upd_flags = '{z: upd_z, dc: upd_dc, c: upd_c};
    assign wr_flags  = '{z: wr_data[B_Z], dc: wr_data[B_DC], c: wr_data[B_C]};
    assign ev        = '{pwr: ev_powerup, clrwdt: ev_clrwdt,
                         sleep: ev_sleep, wdt_to: ev_wdt_to};

    sreg_flag_gen u_gen (
        .op  (alu_op_e'(alu_op)),
        .a   (alu_a),
        .b   (alu_b),
        .cin (cur_flags.c),
        .res (alu_res),
        .flg (gen_flags)
    );

    sreg_flag_reg u_flags (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (wr_hit),
        .wr_flags (wr_flags),
        .upd      (upd_flags),
        .alu      (gen_flags),
        .q        (cur_flags)
    );

    sreg_cause u_cause (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .to_q (to_q),
        .pd_q (pd_q)
    );

    sreg_bank_bits u_hi (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit),
        .wr_val (wr_data[DW-1:B_BANK]),
        .q      (hi_q)
    );

    assign status_q = {hi_q, to_q, pd_q, cur_flags.z, cur_flags.dc, cur_flags.c};
    assign bank_sel = hi_q[0];
    assign alu_z    = gen_flags.z;
    assign alu_dc   = gen_flags.dc;
    assign alu_c    = gen_flags.c;
endmodule

// File: rtl/sreg_status_chk.sv
`timescale 1ns/1ps
module sreg_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_hit,
    input logic [7:0] wr_data,
    input logic       upd_z,
    input logic       upd_dc,
    input logic       upd_c,
    input logic       alu_z,
    input logic       alu_c,
    input logic       ev_powerup,
    input logic       ev_clrwdt,
    input logic       ev_sleep,
    input logic       ev_wdt_to,
    input logic [7:0] status_q
);
    logic any_ev, any_upd;
    assign any_ev  = ev_powerup | ev_clrwdt | ev_sleep | ev_wdt_to;
    assign any_upd = upd_z | upd_dc | upd_c;

    AST_CAUSE_NOT_WRITABLE: assert property (@(posedge clk) disable iff (rst)
        !any_ev |=> $stable(status_q[4:3])); // R3
    AST_HIGH_BITS_WRITTEN: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> status_q[7:5] == $past(wr_data[7:5])); // R3
    AST_Z_FROM_ALU: assert property (@(posedge clk) disable iff (rst)
        upd_z |=> status_q[2] == $past(alu_z)); // R4
    AST_C_FROM_ALU: assert property (@(posedge clk) disable iff (rst)
        upd_c |=> status_q[0] == $past(alu_c)); // R4
    AST_DC_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && any_upd && !upd_dc) |=> $stable(status_q[1])); // R4
    AST_SLEEP_CLEARS_PD: assert property (@(posedge clk) disable iff (rst)
        (ev_sleep && !ev_powerup) |=> !status_q[3]); // R5
    AST_WDT_CLEARS_TO: assert property (@(posedge clk) disable iff (rst)
        (ev_wdt_to && !ev_powerup) |=> !status_q[4]); // R5
    AST_POWERUP_SETS: assert property (@(posedge clk) disable iff (rst)
        ev_powerup |=> status_q[4:3] == 2'b11); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_hit && !any_upd && !any_ev) |=> $stable(status_q)); // R10
endmodule

bind sreg_status sreg_status_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_hit     (wr_hit),
    .wr_data    (wr_data),
    .upd_z      (upd_z),
    .upd_dc     (upd_dc),
    .upd_c      (upd_c),
    .alu_z      (alu_z),
    .alu_c      (alu_c),
    .ev_powerup (ev_powerup),
    .ev_clrwdt  (ev_clrwdt),
    .ev_sleep   (ev_sleep),
    .ev_wdt_to  (ev_wdt_to),
    .status_q   (status_q)
);

// File: tb/sreg_status_test.sv
`timescale 1ns/1ps
module sreg_status_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] alu_op = 3'd0;
    logic [7:0] alu_a = 8'h00;
    logic [7:0] alu_b = 8'h00;
    logic       upd_z = 1'b0, upd_dc = 1'b0, upd_c = 1'b0;
    logic       ev_powerup = 1'b0, ev_clrwdt = 1'b0, ev_sleep = 1'b0, ev_wdt_to = 1'b0;
    logic [7:0] status_q, alu_res;
    logic       bank_sel, alu_z, alu_dc, alu_c;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    sreg_status uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
        .upd_z(upd_z), .upd_dc(upd_dc), .upd_c(upd_c),
        .ev_powerup(ev_powerup), .ev_clrwdt(ev_clrwdt), .ev_sleep(ev_sleep),
        .ev_wdt_to(ev_wdt_to), .status_q(status_q), .bank_sel(bank_sel),
        .alu_res(alu_res), .alu_z(alu_z), .alu_dc(alu_dc), .alu_c(alu_c)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // drive one clocked operation, then return just after the edge that takes it
    task automatic step(input logic we, input logic [7:0] addr, input logic [7:0] data,
                        input logic [2:0] ue, input logic [3:0] evs);
        @(negedge clk);
        wr_en = we; wr_addr = addr; wr_data = data;
        {upd_z, upd_dc, upd_c} = ue;
        {ev_powerup, ev_clrwdt, ev_sleep, ev_wdt_to} = evs;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        {upd_z, upd_dc, upd_c} = 3'b000;
        {ev_powerup, ev_clrwdt, ev_sleep, ev_wdt_to} = 4'b0000;
    endtask

    // reference: {res, z, dc, c} computed arithmetically
    function automatic logic [10:0] ref_gen(input int op, input int a, input int b, input int ci);
        int r; int z; int dc; int c;
        dc = 0; c = 0;
        case (op)
            0: begin r = (a + b) % 256; c = (a + b > 255); dc = ((a % 16) + (b % 16) > 15); end
            1: begin r = (a - b + 256) % 256; c = (a >= b); dc = ((a % 16) >= (b % 16)); end
            2: begin r = (a * 2) % 256 + ci; c = (a >= 128); end
            3: begin r = a / 2 + ci * 128; c = a % 2; end
            4: r = a & b;
            5: r = a | b;
            6: r = a ^ b;
            default: r = a;
        endcase
        z = (r == 0);
        return {r[7:0], z[0], dc[0], c[0]};
    endfunction

    task automatic gen_chk(input string req, input int op, input int a, input int b, input int ci);
        alu_op = op[2:0]; alu_a = a[7:0]; alu_b = b[7:0];
        #1;
        chk(req, {1'b0, alu_res, alu_z, alu_dc, alu_c}, {1'b0, ref_gen(op, a, b, ci)});
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin : main
        logic [7:0] pre, exp;
        logic [10:0] g;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        chk("R1 reset value", {4'h0, status_q}, 12'h018);
        chk("R11 bank after reset", {11'h0, bank_sel}, 12'h0);

        // R3 write with no enables; bits 4:3 untouched
        step(1, 8'h03, 8'hE7, 3'b000, 4'h0);
        chk("R3 write 0xE7", {4'h0, status_q}, 12'h0FF);
        chk("R11 bank follows bit5", {11'h0, bank_sel}, 12'h1);

        // R2 address decode
        step(1, 8'h43, 8'h00, 3'b000, 4'h0);
        chk("R2 addr 0x43 ignored", {4'h0, status_q}, 12'h0FF);
        step(1, 8'h83, 8'h00, 3'b000, 4'h0);
        chk("R2 mirror 0x83 hits", {4'h0, status_q}, 12'h018);
        step(1, 8'h04, 8'hE7, 3'b000, 4'h0);
        chk("R2 addr 0x04 ignored", {4'h0, status_q}, 12'h018);
        step(0, 8'h03, 8'hE7, 3'b000, 4'h0);
        chk("R2 wr_en low ignored", {4'h0, status_q}, 12'h018);

        // R4 every enable combination, with and without a write, two ALU patterns
        for (int pat = 0; pat < 2; pat++) begin
            for (int we = 0; we < 2; we++) begin
                for (int en = 0; en < 8; en++) begin
                    step(1, 8'h03, 8'hA5, 3'b000, 4'h0);
                    pre = status_q;
                    alu_op = 3'd0;
                    alu_a = (pat == 0) ? 8'h88 : 8'h00;
                    alu_b = (pat == 0) ? 8'h88 : 8'h00;
                    g = ref_gen(0, alu_a, alu_b, 0);
                    exp = pre;
                    if (we == 1) exp[7:5] = 3'b010;
                    if (en == 0) begin
                        if (we == 1) exp[2:0] = 3'b010;
                    end else begin
                        if (en[2]) exp[2] = g[2];
                        if (en[1]) exp[1] = g[1];
                        if (en[0]) exp[0] = g[0];
                    end
                    step(we[0], 8'h03, 8'h42, en[2:0], 4'h0);
                    chk($sformatf("R4 en=%0d we=%0d pat=%0d", en, we, pat),
                        {4'h0, status_q}, {4'h0, exp});
                end
            end
        end

        // R4 clear with only zero updated: 000uu1uu
        step(1, 8'h03, 8'hE7, 3'b000, 4'h0);
        alu_op = 3'd4; alu_a = 8'h00; alu_b = 8'h00;
        step(1, 8'h03, 8'h00, 3'b100, 4'h0);
        chk("R4 clear keeps DC C", {4'h0, status_q}, 12'h01F);

        // R5 event sequence, evs = {pwr, clrwdt, sleep, wdt}
        step(0, 8'h00, 8'h00, 3'b000, 4'b0010);
        chk("R5 sleep", {10'h0, status_q[4:3]}, 12'b10);
        step(0, 8'h00, 8'h00, 3'b000, 4'b0001);
        chk("R5 wdt timeout", {10'h0, status_q[4:3]}, 12'b00);
        step(0, 8'h00, 8'h00, 3'b000, 4'b0100);
        chk("R5 clrwdt", {10'h0, status_q[4:3]}, 12'b11);
        step(0, 8'h00, 8'h00, 3'b000, 4'b0001);
        chk("R5 wdt keeps PD", {10'h0, status_q[4:3]}, 12'b01);
        step(0, 8'h00, 8'h00, 3'b000, 4'b0110);
        chk("R5 sleep beats clrwdt", {10'h0, status_q[4:3]}, 12'b10);
        step(1, 8'h03, 8'h18, 3'b000, 4'h0);
        chk("R3 write cannot set PD", {10'h0, status_q[4:3]}, 12'b10);
        step(0, 8'h00, 8'h00, 3'b000, 4'b0011);
        chk("R5 sleep with wdt", {10'h0, status_q[4:3]}, 12'b00);
        step(0, 8'h00, 8'h00, 3'b000, 4'b1011);
        chk("R5 powerup wins", {10'h0, status_q[4:3]}, 12'b11);

        // R10 hold while ALU inputs move
        step(1, 8'h03, 8'hA5, 3'b000, 4'h0);
        pre = status_q;
        for (int k = 0; k < 6; k++) begin
            alu_op = k[2:0]; alu_a = 8'(k * 37); alu_b = 8'(k * 91);
            step(0, 8'h03, 8'hFF, 3'b000, 4'h0);
        end
        chk("R10 idle hold", {4'h0, status_q}, {4'h0, pre});

        // R8 rotates with both carry-in values
        for (int ci = 0; ci < 2; ci++) begin
            step(1, 8'h03, 8'(ci), 3'b000, 4'h0);
            for (int a = 0; a < 256; a++) begin
                gen_chk("R8 rotate left", 2, a, 0, ci);
                gen_chk("R8 rotate right", 3, a, 0, ci);
            end
        end

        // R6 R7 all operand pairs
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                gen_chk("R6 add", 0, a, b, 0);
                gen_chk("R7 sub", 1, a, b, 0);
            end
        end

        // R9 bitwise ops and pass
        for (int op = 4; op < 8; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b += 17) begin
                    gen_chk("R9 logic", op, a, b, 0);
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule